// File: doc/BRIEF.md
# Windowed External Memory Access Controller

This block gives a DSP core indirect access to external memories through a small set of window registers. Software programs a shared control register with two 16-bit transfers: an address word first, then a mode word. The next access to any window arms that window: a read access stores the pair as the window's read descriptor, and a write access stores it as the write descriptor. From then on, each read or write of that window runs one memory transaction on the external port, and the stored address moves forward by a step that the mode selects.

The mode word picks the target memory, the step and the direction in which the descriptor is valid. Program ROM reads take extra high address bits from the low bits of the mode word. Internal RAM writes are only issued inside one fixed address range. A window other than the direct window reaches memory only while one of two status inputs is high. Otherwise it acts as a plain 16-bit register.

Top module: `xmw_top`

## Requirements
- R1: After reset the sequence is idle, all read and write descriptors and all plain window registers hold zero, and memEn is low.
- R2: Control register accesses (busSel equal to NUM_WIN) step a three-state sequence: idle, then address captured, then armed. A write stores busWdata as the address in the first step and as the mode in the second step. A read steps the sequence but stores nothing. An access while armed starts over with a new address word.
- R3: A window access while armed stores {address, mode} into the window's read descriptor (read access) or write descriptor (write access). The sequence returns to idle, memEn stays low and busRdata is zero in that cycle. A window access while only the address is captured also returns the sequence to idle.
- R4: Window DIRECT_WIN always reaches memory. Any other window reaches memory only when statusGp is nonzero. Otherwise a write stores busWdata in that window's plain register, a read returns it, and memEn stays low.
- R5: Data RAM modes use target code 0 with memAddr equal to the 16-bit address. Mode 0x0018 has no step and 0x0818 steps by 1, both for reads and writes. Mode 0x3018 steps by 32 and is valid for reads only.
- R6: Internal RAM write modes use target code 1 with memAddr equal to the low 10 address bits. Mode 0x081c steps by 1 and 0x101c steps by 2.
- R7: An internal RAM write raises memEn only when the address ANDed with 0xfc00 equals 0x8000. The address still steps when it does not.
- R8: Read mode 0x0809 uses target code 2 with memAddr equal to {mode[3:0], address}, and steps by 1. A ROM transaction never has memWe high.
- R9: A mode that is not listed for the access direction gives no memory transaction, and busRdata is zero.
- R10: Every window keeps its read and write descriptors separately, and each one steps only on accesses of its own direction.
- R11: The descriptor address wraps modulo 2^16 when it steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access strobe |
| busSel | input | SEL_W | Window index 0..NUM_WIN-1; NUM_WIN selects the control register |
| busWrite | input | 1 | 1 = write access, 0 = read access |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, same cycle |
| statusGp | input | 2 | Status bits that route the non-direct windows to memory |
| memEn | output | 1 | Memory transaction strobe |
| memWe | output | 1 | Memory write enable |
| memTarget | output | 2 | 0 data RAM, 1 internal RAM, 2 program ROM |
| memAddr | output | 16+ROM_BANK_W | Word address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, same cycle |

## Verification
The bench uses the default parameters: five windows with window 4 as the direct one, a 4-bit ROM bank field and a 10-bit internal RAM index. This lets one run compare the always-routed window with the status-gated windows. It also places the ROM bank bits in the upper part of the 20-bit address and checks that an index in the 10-bit internal RAM range is accepted while an address just below the valid range is rejected. The memory model returns data computed from target and address, so every read check also confirms where the transaction went.

// File: rtl/xmw_pkg.sv
package xmw_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ADDR  = 2'd1,
    SEQ_ARMED = 2'd2
  } seqState_t;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_IRAM = 2'd1,
    TGT_ROM  = 2'd2
  } memTgt_t;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic capAddr;
    logic capMode;
    logic bindRd;
    logic bindWr;
    logic memRd;
    logic memWr;
    logic plainWr;
    logic plainRd;
  } xmwStrobe_t;

  typedef struct packed {
    logic    valid;
    memTgt_t target;
    logic [5:0] step;
  } modeDec_t;

  localparam logic [15:0] MODE_DRAM       = 16'h0018;
  localparam logic [15:0] MODE_DRAM_INC1  = 16'h0818;
  localparam logic [15:0] MODE_DRAM_INC32 = 16'h3018;
  localparam logic [15:0] MODE_IRAM_INC1  = 16'h081c;
  localparam logic [15:0] MODE_IRAM_INC2  = 16'h101c;
  localparam logic [15:0] MODE_ROM_INC1   = 16'h0809;

  localparam logic [15:0] IRAM_MASK  = 16'hfc00;
  localparam logic [15:0] IRAM_MATCH = 16'h8000;

  function automatic modeDec_t decodeMode(input logic [15:0] mode, input logic isWr);
    modeDec_t d;
    d.valid  = 1'b0;
    d.target = TGT_DRAM;
    d.step   = 6'd0;
    case (mode)
      MODE_DRAM:      begin d.valid = 1'b1; d.step = 6'd0; end
      MODE_DRAM_INC1: begin d.valid = 1'b1; d.step = 6'd1; end
      MODE_DRAM_INC32: if (!isWr) begin d.valid = 1'b1; d.step = 6'd32; end
      MODE_IRAM_INC1: if (isWr) begin d.valid = 1'b1; d.target = TGT_IRAM; d.step = 6'd1; end
      MODE_IRAM_INC2: if (isWr) begin d.valid = 1'b1; d.target = TGT_IRAM; d.step = 6'd2; end
      MODE_ROM_INC1:  if (!isWr) begin d.valid = 1'b1; d.target = TGT_ROM; d.step = 6'd1; end
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/xmw_control.sv
module xmw_control
  import xmw_pkg::*;
#(
  parameter int NUM_WIN    = 5,
  parameter int DIRECT_WIN = 4,
  localparam int SEL_W     = $clog2(NUM_WIN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic [SEL_W-1:0] busSel,
  input  logic             busWrite,
  input  logic [1:0]       statusGp,
  output xmwStrobe_t       strobe
);

  localparam logic [SEL_W-1:0] CTRL_SEL   = SEL_W'(NUM_WIN);
  localparam logic [SEL_W-1:0] DIRECT_SEL = SEL_W'(DIRECT_WIN);

  seqState_t seqState, seqNext;
  logic isCtrl, isWin, routed;

  assign isCtrl = busValid && (busSel == CTRL_SEL);
  assign isWin  = busValid && (busSel < CTRL_SEL);
  assign routed = (busSel == DIRECT_SEL) || (|statusGp);

  always_comb begin
    strobe  = '0;
    seqNext = seqState;
    if (isCtrl) begin
      case (seqState)
        SEQ_ADDR: begin
          strobe.capMode = busWrite;
          seqNext        = SEQ_ARMED;
        end
        default: begin
          strobe.capAddr = busWrite;
          seqNext        = SEQ_ADDR;
        end
      endcase
    end else if (isWin) begin
      seqNext = SEQ_IDLE;
      if (seqState == SEQ_ARMED) begin
        strobe.bindRd = !busWrite;
        strobe.bindWr = busWrite;
      end else if (routed) begin
        strobe.memRd = !busWrite;
        strobe.memWr = busWrite;
      end else begin
        strobe.plainWr = busWrite;
        strobe.plainRd = !busWrite;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) seqState <= SEQ_IDLE;
    else       seqState <= seqNext;
  end

  // R2
  seq_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_IDLE && isCtrl) |=> (seqState == SEQ_ADDR));

  // R3
  armed_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_ARMED && isWin) |=> (seqState == SEQ_IDLE));

  // R2
  rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_ARMED && isCtrl) |=> (seqState == SEQ_ADDR));

endmodule

// File: rtl/xmw_datapath.sv
module xmw_datapath
  import xmw_pkg::*;
#(
  parameter int NUM_WIN     = 5,
  parameter int ROM_BANK_W  = 4,
  parameter int IRAM_IDX_W  = 10,
  localparam int SEL_W      = $clog2(NUM_WIN + 1),
  localparam int MEM_ADDR_W = 16 + ROM_BANK_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xmwStrobe_t            strobe,
  input  logic [SEL_W-1:0]      busSel,
  input  logic                  busWrite,
  input  logic [15:0]           busWdata,
  output logic [15:0]           busRdata,
  output logic                  memEn,
  output logic                  memWe,
  output logic [1:0]            memTarget,
  output logic [MEM_ADDR_W-1:0] memAddr,
  output logic [15:0]           memWdata,
  input  logic [15:0]           memRdata
);

  localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_WIN);

  logic [31:0] rdDesc   [NUM_WIN];
  logic [31:0] wrDesc   [NUM_WIN];
  logic [15:0] plainReg [NUM_WIN];
  logic [15:0] addrWord, modeWord;

  logic        winOk;
  logic [31:0] selDesc;
  logic [15:0] descAddr, descMode, nextAddr;
  modeDec_t    dec;
  logic        iramOk, memAct;

  assign winOk    = busSel < CTRL_SEL;
  assign selDesc  = !winOk ? 32'd0 : (busWrite ? wrDesc[busSel] : rdDesc[busSel]);
  assign descAddr = selDesc[31:16];
  assign descMode = selDesc[15:0];
  assign dec      = decodeMode(descMode, busWrite);
  assign iramOk   = (descAddr & IRAM_MASK) == IRAM_MATCH;
  assign memAct   = strobe.memRd || strobe.memWr;
  assign nextAddr = descAddr + 16'(dec.step);

  always_comb begin
    memEn = memAct && dec.valid;
    if (dec.target == TGT_IRAM && !iramOk) memEn = 1'b0;
  end

  assign memWe     = memEn && strobe.memWr;
  assign memTarget = dec.target;
  assign memWdata  = busWdata;

  always_comb begin
    case (dec.target)
      TGT_ROM:  memAddr = {descMode[ROM_BANK_W-1:0], descAddr};
      TGT_IRAM: memAddr = MEM_ADDR_W'(descAddr[IRAM_IDX_W-1:0]);
      default:  memAddr = MEM_ADDR_W'(descAddr);
    endcase
  end

  always_comb begin
    busRdata = 16'd0;
    if (strobe.memRd && memEn) busRdata = memRdata;
    else if (strobe.plainRd && winOk) busRdata = plainReg[busSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        rdDesc[w]   <= 32'd0;
        wrDesc[w]   <= 32'd0;
        plainReg[w] <= 16'd0;
      end
      addrWord <= 16'd0;
      modeWord <= 16'd0;
    end else begin
      if (strobe.capAddr) addrWord <= busWdata;
      if (strobe.capMode) modeWord <= busWdata;
      if (winOk) begin
        if (strobe.bindRd) rdDesc[busSel] <= {addrWord, modeWord};
        if (strobe.bindWr) wrDesc[busSel] <= {addrWord, modeWord};
        if (strobe.plainWr) plainReg[busSel] <= busWdata;
        if (strobe.memRd && dec.valid) rdDesc[busSel][31:16] <= nextAddr;
        if (strobe.memWr && dec.valid) wrDesc[busSel][31:16] <= nextAddr;
      end
    end
  end

  // R3
  bind_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bindRd || strobe.bindWr) |-> (!memEn && busRdata == 16'd0));

  // R8
  rom_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memTarget == 2'd2) |-> !memWe);

  // R4
  plain_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.plainRd || strobe.plainWr) |-> !memEn);

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_stepChk
      // R5
      rd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.memRd && busSel == SEL_W'(w) && rdDesc[w][15:0] == MODE_DRAM_INC1)
        |=> (rdDesc[w][31:16] == $past(rdDesc[w][31:16]) + 16'd1));
    end
  endgenerate

endmodule

// File: rtl/xmw_top.sv
module xmw_top
  import xmw_pkg::*;
#(
  parameter int NUM_WIN     = 5,
  parameter int DIRECT_WIN  = 4,
  parameter int ROM_BANK_W  = 4,
  parameter int IRAM_IDX_W  = 10,
  localparam int SEL_W      = $clog2(NUM_WIN + 1),
  localparam int MEM_ADDR_W = 16 + ROM_BANK_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic [SEL_W-1:0]      busSel,
  input  logic                  busWrite,
  input  logic [15:0]           busWdata,
  output logic [15:0]           busRdata,
  input  logic [1:0]            statusGp,
  output logic                  memEn,
  output logic                  memWe,
  output logic [1:0]            memTarget,
  output logic [MEM_ADDR_W-1:0] memAddr,
  output logic [15:0]           memWdata,
  input  logic [15:0]           memRdata
);

  xmwStrobe_t strobe;

  xmw_control #(
    .NUM_WIN    (NUM_WIN),
    .DIRECT_WIN (DIRECT_WIN)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busSel   (busSel),
    .busWrite (busWrite),
    .statusGp (statusGp),
    .strobe   (strobe)
  );

  xmw_datapath #(
    .NUM_WIN    (NUM_WIN),
    .ROM_BANK_W (ROM_BANK_W),
    .IRAM_IDX_W (IRAM_IDX_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .memEn     (memEn),
    .memWe     (memWe),
    .memTarget (memTarget),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRdata  (memRdata)
  );

endmodule

// File: tb/sim_xmw_top.sv
`timescale 1ns/100ps
module sim_xmw_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic [2:0]  busSel = 3'd0;
  logic        busWrite = 1'b0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic [1:0]  statusGp = 2'd0;
  logic        memEn, memWe;
  logic [1:0]  memTarget;
  logic [19:0] memAddr;
  logic [15:0] memWdata, memRdata;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  logic [15:0] sRd, sWd;
  logic        sEn, sWe;
  logic [1:0]  sTgt;
  logic [19:0] sAddr;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] memModel(input logic [1:0] t, input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h000} ^ {6'd0, t, 8'h00};
  endfunction

  assign memRdata = memModel(memTarget, memAddr);

  xmw_top u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busSel(busSel),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .statusGp(statusGp), .memEn(memEn), .memWe(memWe), .memTarget(memTarget),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] sel, input logic wr, input logic [15:0] d);
    @(negedge clk);
    busValid = 1'b1; busSel = sel; busWrite = wr; busWdata = d;
    #1;
    sRd = busRdata; sEn = memEn; sWe = memWe; sTgt = memTarget;
    sAddr = memAddr; sWd = memWdata;
    @(posedge clk);
    #0.5;
    busValid = 1'b0;
  endtask

  task automatic prog(input logic [2:0] sel, input logic wr, input logic [15:0] a, input logic [15:0] m);
    access(3'd5, 1'b1, a);
    access(3'd5, 1'b1, m);
    access(sel, wr, 16'h5a5a);
    check("R3 bind no mem", {31'd0, sEn}, 32'd0);
    check("R3 bind rdata", {16'd0, sRd}, 32'd0);
  endtask

  task automatic expRead(input string req, input logic [1:0] t, input logic [19:0] a);
    check({req, " en"}, {31'd0, sEn}, 32'd1);
    check({req, " we"}, {31'd0, sWe}, 32'd0);
    check({req, " tgt"}, {30'd0, sTgt}, {30'd0, t});
    check({req, " addr"}, {12'd0, sAddr}, {12'd0, a});
    check({req, " data"}, {16'd0, sRd}, {16'd0, memModel(t, a)});
  endtask

  task automatic expWrite(input string req, input logic [1:0] t, input logic [19:0] a, input logic [15:0] d);
    check({req, " en"}, {31'd0, sEn}, 32'd1);
    check({req, " we"}, {31'd0, sWe}, 32'd1);
    check({req, " tgt"}, {30'd0, sTgt}, {30'd0, t});
    check({req, " addr"}, {12'd0, sAddr}, {12'd0, a});
    check({req, " wdata"}, {16'd0, sWd}, {16'd0, d});
  endtask

  task automatic tReset;
    #1;
    check("R1 memEn idle", {31'd0, memEn}, 32'd0);
    access(3'd0, 1'b0, 0);
    check("R1 plain zero", {16'd0, sRd}, 32'd0);
    access(3'd4, 1'b0, 0);
    check("R1 desc zero en", {31'd0, sEn}, 32'd0);
    check("R1 desc zero rd", {16'd0, sRd}, 32'd0);
  endtask

  task automatic tSequence;
    access(3'd5, 1'b1, 16'h0200);
    access(3'd5, 1'b1, 16'h0818);
    access(3'd5, 1'b1, 16'h0300);
    access(3'd5, 1'b1, 16'h0018);
    access(3'd4, 1'b0, 0);
    check("R2 bind after restart en", {31'd0, sEn}, 32'd0);
    access(3'd4, 1'b0, 0);
    expRead("R2 replaced addr", 2'd0, 20'h00300);
    access(3'd4, 1'b0, 0);
    expRead("R5 no step", 2'd0, 20'h00300);
    access(3'd5, 1'b1, 16'h0400);
    access(3'd5, 1'b0, 0);
    access(3'd4, 1'b0, 0);
    check("R2 ctrl read arms", {31'd0, sEn}, 32'd0);
    access(3'd4, 1'b0, 0);
    expRead("R2 ctrl read keeps mode", 2'd0, 20'h00400);
    access(3'd5, 1'b1, 16'h0500);
    access(3'd4, 1'b0, 0);
    expRead("R3 addr-only dropped", 2'd0, 20'h00400);
    access(3'd5, 1'b1, 16'h0818);
    access(3'd4, 1'b0, 0);
    expRead("R3 restart not armed", 2'd0, 20'h00400);
  endtask

  task automatic tRouting;
    statusGp = 2'b00;
    access(3'd1, 1'b1, 16'habcd);
    check("R4 plain write no mem", {31'd0, sEn}, 32'd0);
    statusGp = 2'b01;
    prog(3'd1, 1'b0, 16'h0020, 16'h0818);
    access(3'd1, 1'b0, 0);
    expRead("R4 gp bit5 routed", 2'd0, 20'h00020);
    statusGp = 2'b00;
    access(3'd1, 1'b0, 0);
    check("R4 plain read", {16'd0, sRd}, 32'h0000abcd);
    check("R4 plain read no mem", {31'd0, sEn}, 32'd0);
    statusGp = 2'b10;
    access(3'd1, 1'b0, 0);
    expRead("R4 gp bit6 routed", 2'd0, 20'h00021);
  endtask

  task automatic tDataRam;
    statusGp = 2'b01;
    prog(3'd0, 1'b0, 16'h1000, 16'h3018);
    access(3'd0, 1'b0, 0);
    expRead("R5 step32 first", 2'd0, 20'h01000);
    access(3'd0, 1'b0, 0);
    expRead("R5 step32 second", 2'd0, 20'h01020);
    prog(3'd0, 1'b1, 16'h0040, 16'h0818);
    access(3'd0, 1'b1, 16'h1111);
    expWrite("R5 write inc1 first", 2'd0, 20'h00040, 16'h1111);
    access(3'd0, 1'b1, 16'h2222);
    expWrite("R5 write inc1 second", 2'd0, 20'h00041, 16'h2222);
  endtask

  task automatic tIntRam;
    statusGp = 2'b01;
    prog(3'd2, 1'b1, 16'h8005, 16'h081c);
    access(3'd2, 1'b1, 16'h0a0a);
    expWrite("R6 iram inc1 first", 2'd1, 20'h00005, 16'h0a0a);
    access(3'd2, 1'b1, 16'h0b0b);
    expWrite("R6 iram inc1 second", 2'd1, 20'h00006, 16'h0b0b);
    prog(3'd3, 1'b1, 16'h83f0, 16'h101c);
    access(3'd3, 1'b1, 16'h0c0c);
    expWrite("R6 iram inc2 first", 2'd1, 20'h003f0, 16'h0c0c);
    access(3'd3, 1'b1, 16'h0d0d);
    expWrite("R6 iram inc2 second", 2'd1, 20'h003f2, 16'h0d0d);
    prog(3'd2, 1'b1, 16'h7fff, 16'h081c);
    access(3'd2, 1'b1, 16'h0e0e);
    check("R7 out of range no write", {31'd0, sEn}, 32'd0);
    access(3'd2, 1'b1, 16'h0f0f);
    expWrite("R7 stepped into range", 2'd1, 20'h00000, 16'h0f0f);
  endtask

  task automatic tRom;
    statusGp = 2'b00;
    prog(3'd4, 1'b0, 16'h0100, 16'h0809);
    access(3'd4, 1'b0, 0);
    expRead("R8 rom first", 2'd2, 20'h90100);
    access(3'd4, 1'b0, 0);
    expRead("R8 rom second", 2'd2, 20'h90101);
  endtask

  task automatic tUnknown;
    prog(3'd4, 1'b0, 16'h0000, 16'h1234);
    access(3'd4, 1'b0, 0);
    check("R9 unknown read no mem", {31'd0, sEn}, 32'd0);
    check("R9 unknown read zero", {16'd0, sRd}, 32'd0);
    prog(3'd4, 1'b1, 16'h0010, 16'h3018);
    access(3'd4, 1'b1, 16'h7777);
    check("R9 read-only mode on write", {31'd0, sEn}, 32'd0);
  endtask

  task automatic tIndependent;
    statusGp = 2'b01;
    prog(3'd1, 1'b0, 16'h0700, 16'h0818);
    prog(3'd1, 1'b1, 16'h0900, 16'h0018);
    access(3'd1, 1'b0, 0);
    expRead("R10 rd desc", 2'd0, 20'h00700);
    access(3'd1, 1'b1, 16'h3333);
    expWrite("R10 wr desc", 2'd0, 20'h00900, 16'h3333);
    access(3'd1, 1'b0, 0);
    expRead("R10 rd stepped alone", 2'd0, 20'h00701);
    access(3'd1, 1'b1, 16'h4444);
    expWrite("R10 wr unchanged", 2'd0, 20'h00900, 16'h4444);
  endtask

  task automatic tWrap;
    statusGp = 2'b01;
    prog(3'd2, 1'b0, 16'hffff, 16'h0818);
    access(3'd2, 1'b0, 0);
    expRead("R11 top addr", 2'd0, 20'h0ffff);
    access(3'd2, 1'b0, 0);
    expRead("R11 wrapped", 2'd0, 20'h00000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rstN = 1'b1;
    tReset();
    tSequence();
    tRouting();
    tDataRam();
    tIntRam();
    tRom();
    tUnknown();
    tIndependent();
    tWrap();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule